// File: doc/BRIEF.md
# Platform System Control Register Bank

This block is a byte-wide bank of I/O-port registers for a legacy desktop-style platform. A processor-side bus master presents a port address with a write strobe and write data, or with a read strobe. The bank decodes the full port address and either updates a small set of control bits, emits a pulse, or returns a byte one cycle later on the read data bus.

The live controls are a soft-reset level, a little-endian mode flag, a disk activity light flag, a four-bit cache-control field and a single I/O map-mode bit. Two further ports produce single-cycle lock-toggle pulses toward a non-volatile memory device. Several ports return hard-wired identification and equipment-presence bytes. Reads of ports that decode to nothing return all-ones. Writes to ports that decode to nothing raise a one-cycle error strobe and leave all state untouched.

The reset controller, the non-volatile memory and the processor lie outside the block; they see only its output pins.

Top module: `sysctl_regbank`

## Requirements
- R1: A write to port 0x092 drives `soft_reset` to the value of write data bit 0 from the next cycle on, and holds it until the next write to that port.
- R2: A write to port 0x092 drives `le_mode` to write data bit 1 from the next cycle on. A read of port 0x092 returns 0x00 whatever was written.
- R3: A write to port 0x808 stores write data bit 0 as `disk_light`. Other data bits have no effect.
- R4: Any write to port 0x810 makes `lock1_pulse` high for exactly the one cycle after the write. Any write to port 0x812 does the same for `lock2_pulse`. Neither pulse occurs at any other time.
- R5: A write to port 0x81C stores write data bits 3:0 in `cache_ctl`. A read of port 0x81C returns that field in bits 3:0 with bits 7:4 zero.
- R6: A write to port 0x850 stores write data bit 0 as `map_mode`. A read of port 0x850 returns it in bit 0 with all other bits zero.
- R7: Reads return fixed bytes: port 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00 and 0x823 gives 0x03.
- R8: A read of any other port, including 0x814 and aliases such as 0x1092, returns 0xFF. Writes to 0x800, 0x802, 0x803 and 0x814 change no output and raise no error.
- R9: A write to a port outside the set {0x092, 0x800, 0x802, 0x803, 0x808, 0x810, 0x812, 0x814, 0x81C, 0x850} raises `err_stb` for exactly the one following cycle. It changes no stored bit and produces no pulse.
- R10: While `rst` is high at a clock edge, every stored bit, both pulses, `err_stb` and `rdata` become zero.
- R11: Read data is registered. `rdata` takes the value of the addressed port on the edge that samples `rd`, and holds it while `rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W (16) | Port address |
| wdata | input | DATA_W (8) | Write data |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe |
| rdata | output | DATA_W (8) | Registered read data |
| err_stb | output | 1 | One-cycle strobe for a write to an unmapped port |
| soft_reset | output | 1 | Soft-reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| disk_light | output | 1 | Disk activity light state |
| lock1_pulse | output | 1 | Lock 1 toggle pulse |
| lock2_pulse | output | 1 | Lock 2 toggle pulse |
| cache_ctl | output | CACHE_W (4) | Cache-control field |
| map_mode | output | 1 | I/O map-mode bit |

## Verification
The bench builds the bank with its defaults: a 16-bit address, 8-bit data and a 4-bit cache field. The full 16-bit decode lets the bench reach alias ports such as 0x1092 and 0x1810, which match a live port in their low 12 bits. These must read as 0xFF and must raise the error strobe on a write. Driving every data byte with unused high bits set lets the bench confirm that only the documented bits are captured.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int CACHE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              err_stb,
  output logic              soft_reset,
  output logic              le_mode,
  output logic              disk_light,
  output logic              lock1_pulse,
  output logic              lock2_pulse,
  output logic [CACHE_W-1:0] cache_ctl,
  output logic              map_mode
);

  localparam logic [ADDR_W-1:0] P_RSTEND  = ADDR_W'(16'h0092);
  localparam logic [ADDR_W-1:0] P_CPUID   = ADDR_W'(16'h0800);
  localparam logic [ADDR_W-1:0] P_FEAT    = ADDR_W'(16'h0802);
  localparam logic [ADDR_W-1:0] P_STAT    = ADDR_W'(16'h0803);
  localparam logic [ADDR_W-1:0] P_DISK    = ADDR_W'(16'h0808);
  localparam logic [ADDR_W-1:0] P_EQUIP   = ADDR_W'(16'h080C);
  localparam logic [ADDR_W-1:0] P_LOCK1   = ADDR_W'(16'h0810);
  localparam logic [ADDR_W-1:0] P_LOCK2   = ADDR_W'(16'h0812);
  localparam logic [ADDR_W-1:0] P_INVAL   = ADDR_W'(16'h0814);
  localparam logic [ADDR_W-1:0] P_KEY     = ADDR_W'(16'h0818);
  localparam logic [ADDR_W-1:0] P_CACHE   = ADDR_W'(16'h081C);
  localparam logic [ADDR_W-1:0] P_L2INFO  = ADDR_W'(16'h0823);
  localparam logic [ADDR_W-1:0] P_MAP     = ADDR_W'(16'h0850);

  localparam logic [DATA_W-1:0] V_CPUID  = DATA_W'(8'hEF);
  localparam logic [DATA_W-1:0] V_FEAT   = DATA_W'(8'hAD);
  localparam logic [DATA_W-1:0] V_STAT   = DATA_W'(8'hE0);
  localparam logic [DATA_W-1:0] V_EQUIP  = DATA_W'(8'h3C);
  localparam logic [DATA_W-1:0] V_EXTF   = DATA_W'(8'h39);
  localparam logic [DATA_W-1:0] V_L2INFO = DATA_W'(8'h03);

  logic              wr_ok;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    case (addr)
      P_RSTEND, P_CPUID, P_FEAT, P_STAT, P_DISK, P_LOCK1,
      P_LOCK2, P_INVAL, P_CACHE, P_MAP: wr_ok = 1'b1;
      default:                          wr_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (addr)
      P_RSTEND: rd_mux = '0;
      P_CPUID:  rd_mux = V_CPUID;
      P_FEAT:   rd_mux = V_FEAT;
      P_STAT:   rd_mux = V_STAT;
      P_EQUIP:  rd_mux = V_EQUIP;
      P_LOCK1:  rd_mux = V_EXTF;
      P_KEY:    rd_mux = '0;
      P_CACHE:  rd_mux = DATA_W'(cache_ctl);
      P_L2INFO: rd_mux = V_L2INFO;
      P_MAP:    rd_mux = DATA_W'(map_mode);
      default:  rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_reset  <= 1'b0;
      le_mode     <= 1'b0;
      disk_light  <= 1'b0;
      cache_ctl   <= '0;
      map_mode    <= 1'b0;
      lock1_pulse <= 1'b0;
      lock2_pulse <= 1'b0;
      err_stb     <= 1'b0;
    end else begin
      lock1_pulse <= wr && addr == P_LOCK1;
      lock2_pulse <= wr && addr == P_LOCK2;
      err_stb     <= wr && !wr_ok;
      if (wr) begin
        case (addr)
          P_RSTEND: begin
            soft_reset <= wdata[0];
            le_mode    <= wdata[1];
          end
          P_DISK:  disk_light <= wdata[0];
          P_CACHE: cache_ctl  <= wdata[CACHE_W-1:0];
          P_MAP:   map_mode   <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  // R4
  lock1_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == P_LOCK1) |=> lock1_pulse);
  // R4
  lock1_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == P_LOCK1) |=> !lock1_pulse);
  // R4
  lock2_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == P_LOCK2) |=> lock2_pulse);
  // R9
  bad_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !wr_ok) |=> (err_stb && $stable(cache_ctl) && $stable(map_mode)
                        && $stable(soft_reset) && $stable(le_mode)
                        && $stable(disk_light) && !lock1_pulse && !lock2_pulse));
  // R8
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && (addr == P_CPUID || addr == P_INVAL)) |=> !err_stb);
  // R1
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == P_RSTEND) |=> soft_reset == $past(wdata[0]));
  // R2
  port92_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == P_RSTEND) |=> rdata == '0);
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));

endmodule

// File: tb/sysctl_regbank_bench.sv
`timescale 1ns/1ps
module sysctl_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;
  logic        err_stb, soft_reset, le_mode, disk_light;
  logic        lock1_pulse, lock2_pulse, map_mode;
  logic [3:0]  cache_ctl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sysctl_regbank u_sysctl_regbank (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .err_stb(err_stb), .soft_reset(soft_reset),
    .le_mode(le_mode), .disk_light(disk_light), .lock1_pulse(lock1_pulse),
    .lock2_pulse(lock2_pulse), .cache_ctl(cache_ctl), .map_mode(map_mode)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_port(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_port(logic [15:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic t_reset;
    check("R10 soft_reset", soft_reset, 0);
    check("R10 le_mode", le_mode, 0);
    check("R10 disk_light", disk_light, 0);
    check("R10 cache_ctl", cache_ctl, 0);
    check("R10 map_mode", map_mode, 0);
    check("R10 pulses", {lock1_pulse, lock2_pulse, err_stb}, 0);
    check("R10 rdata", rdata, 0);
  endtask

  task automatic t_port92;
    wr_port(16'h0092, 8'hFD);
    check("R1 soft_reset set", soft_reset, 1);
    check("R2 le_mode clear", le_mode, 0);
    check("R9 no err on mapped", err_stb, 0);
    wr_port(16'h0092, 8'hFE);
    check("R1 soft_reset clear", soft_reset, 0);
    check("R2 le_mode set", le_mode, 1);
    rd_port(16'h0092, 8'h00, "R2 port92 reads zero");
    check("R2 le_mode kept after read", le_mode, 1);
    wr_port(16'h0092, 8'h00);
    check("R2 le_mode clear", le_mode, 0);
  endtask

  task automatic t_disk;
    wr_port(16'h0808, 8'hFF);
    check("R3 disk set", disk_light, 1);
    wr_port(16'h0808, 8'hFE);
    check("R3 disk clear", disk_light, 0);
  endtask

  task automatic t_locks;
    wr_port(16'h0810, 8'h00);
    check("R4 lock1 pulse", {lock1_pulse, lock2_pulse}, 2'b10);
    @(negedge clk);
    check("R4 lock1 ends", lock1_pulse, 0);
    wr_port(16'h0812, 8'h5A);
    check("R4 lock2 pulse", {lock1_pulse, lock2_pulse}, 2'b01);
    @(negedge clk);
    check("R4 lock2 ends", lock2_pulse, 0);
    rd_port(16'h0812, 8'hFF, "R8 lock2 port reads ff");
    check("R4 no pulse on read", {lock1_pulse, lock2_pulse}, 0);
  endtask

  task automatic t_cache_map;
    wr_port(16'h081C, 8'hA7);
    check("R5 cache low bits", cache_ctl, 4'h7);
    rd_port(16'h081C, 8'h07, "R5 cache readback");
    wr_port(16'h081C, 8'h5C);
    rd_port(16'h081C, 8'h0C, "R5 cache readback 2");
    wr_port(16'h0850, 8'hFF);
    check("R6 map set", map_mode, 1);
    rd_port(16'h0850, 8'h01, "R6 map readback");
    wr_port(16'h0850, 8'hFE);
    rd_port(16'h0850, 8'h00, "R6 map cleared");
  endtask

  task automatic t_constants;
    rd_port(16'h0800, 8'hEF, "R7 0x800");
    rd_port(16'h0802, 8'hAD, "R7 0x802");
    rd_port(16'h0803, 8'hE0, "R7 0x803");
    rd_port(16'h080C, 8'h3C, "R7 0x80C");
    rd_port(16'h0810, 8'h39, "R7 0x810");
    rd_port(16'h0818, 8'h00, "R7 0x818");
    rd_port(16'h0823, 8'h03, "R7 0x823");
  endtask

  task automatic t_unmapped_read;
    rd_port(16'h0814, 8'hFF, "R8 0x814 reads ff");
    rd_port(16'h1092, 8'hFF, "R8 alias 0x1092");
    rd_port(16'h0801, 8'hFF, "R8 0x801");
    rd_port(16'hFFFF, 8'hFF, "R8 0xFFFF");
  endtask

  task automatic t_ignored_write;
    wr_port(16'h081C, 8'h09);
    wr_port(16'h0800, 8'h00);
    check("R8 ignore 0x800 no err", err_stb, 0);
    wr_port(16'h0814, 8'hFF);
    check("R8 ignore 0x814 no err", err_stb, 0);
    wr_port(16'h0803, 8'h11);
    check("R8 ignore state", {soft_reset, le_mode, disk_light, map_mode, cache_ctl}, 8'h09);
    rd_port(16'h0800, 8'hEF, "R8 0x800 still const");
    rd_port(16'h0803, 8'hE0, "R8 0x803 still const");
  endtask

  task automatic t_bad_write;
    wr_port(16'h0092, 8'h02);
    wr_port(16'h0808, 8'h01);
    wr_port(16'h080C, 8'hFF);
    check("R9 err strobe", err_stb, 1);
    check("R9 state kept", {soft_reset, le_mode, disk_light, map_mode, cache_ctl}, 8'h69);
    @(negedge clk);
    check("R9 err one cycle", err_stb, 0);
    wr_port(16'h1092, 8'h01);
    check("R9 alias err", err_stb, 1);
    check("R9 alias no reset", soft_reset, 0);
    wr_port(16'h1810, 8'h00);
    check("R9 alias no pulse", {lock1_pulse, err_stb}, 2'b01);
    wr_port(16'h0818, 8'h00);
    check("R9 key write err", err_stb, 1);
  endtask

  task automatic t_hold;
    rd_port(16'h0802, 8'hAD, "R11 load");
    @(negedge clk); addr = 16'h0800;
    @(negedge clk);
    check("R11 holds without rd", rdata, 8'hAD);
    wr_port(16'h081C, 8'h03);
    check("R11 hold over write", rdata, 8'hAD);
  endtask

  task automatic t_rereset;
    wr_port(16'h0092, 8'h03);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    t_reset();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_port92();
    t_disk();
    t_locks();
    t_cache_map();
    t_constants();
    t_unmapped_read();
    t_ignored_write();
    t_bad_write();
    t_hold();
    t_rereset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule